// File: doc/BRIEF.md
# Processor Fault Entry Sequencer

This block performs the register side of entering a processor exception for three fault sources: a translation-buffer conflict (more than one translation entry matched one address), a bus error raised on a data access, and a bus error raised on an instruction fetch. The pipeline raises a one-cycle request for each source and presents the fault context with it: the current program counter, the address of the oldest instruction not yet issued, the failing virtual address, its page number, and a flag that says which translation buffer reported the conflict.

In the clock edge that samples a request, the block saves the status word, writes the entry status, chooses a return address and a vector address, and, for a translation conflict only, records the failing address in its fault registers. In the following cycle it pulses `entry_taken` with a cause code and a flag that says whether the interrupted code may be resumed. When no fault is pending, software may write the vector base, the status word and the address-space tag through simple write strobes.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `status_q` is 16'h0078 (mode field bits [4:2] = 3'b110, bits 5 and 6 set, all other bits 0), and every other output register, `entry_taken`, `entry_cause` and `entry_resumable` are zero.
- R2: On an entry, `saved_status_q` receives the value `status_q` had just before that entry.
- R3: On an entry, `status_q` clears bits 0 and 1, sets bits [4:2] to 3'b110, sets bits 5 and 6, and keeps every bit above 6.
- R4: On an entry, `pc_q` becomes `vec_base_q` plus 0x04 for a translation conflict, plus 0x08 for a data bus error, plus 0x0C for a fetch bus error.
- R5: On an entry, `ret_addr_q` becomes `ctx_pc` for a translation conflict or a fetch bus error, and `ctx_unissued_pc` for a data bus error.
- R6: On a translation conflict, `fault_va_q` takes `ctx_fault_va`, `tlb_hi_q[31:12]` takes `ctx_page`, and `tlb_hi_q[8]` takes `ctx_itlb` (1 = instruction buffer, 0 = data buffer); `tlb_hi_q[11:9]` reads as zero.
- R7: On a translation conflict, the address-space tag `tlb_hi_q[7:0]` keeps its value.
- R8: `entry_resumable` is 1 with a fetch bus error entry and 0 with the other two causes and when no entry is reported.
- R9: Requests arriving together are served with the translation conflict first, the data bus error second and the fetch bus error last; the others in that cycle are dropped and cause no later entry.
- R10: A request sampled at one clock edge updates all registers at that edge and makes `entry_taken` high for exactly the next cycle, with `entry_cause` 2'd1 (translation conflict), 2'd2 (data bus error) or 2'd3 (fetch bus error); with no entry the code is 2'd0.
- R11: A data or fetch bus error entry leaves `fault_va_q` and `tlb_hi_q` unchanged.
- R12: `vb_wr_en`, `sr_wr_en` and `asid_wr_en` load `vec_base_q`, `status_q` and `tlb_hi_q[7:0]` at the sampling edge when no request is present; in a cycle with any request all three writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_tlb_conflict | input | 1 | Translation conflict request pulse |
| req_data_berr | input | 1 | Data access bus error request pulse |
| req_fetch_berr | input | 1 | Instruction fetch bus error request pulse |
| ctx_pc | input | 32 | Program counter of the current instruction |
| ctx_unissued_pc | input | 32 | Address of the oldest instruction not yet issued |
| ctx_fault_va | input | 32 | Failing virtual address |
| ctx_page | input | 20 | Failing virtual page number |
| ctx_itlb | input | 1 | 1 when the instruction buffer reported the conflict |
| vb_wr_en | input | 1 | Vector base write strobe |
| vb_wr_data | input | 32 | Vector base write value |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | 16 | Status word write value |
| asid_wr_en | input | 1 | Address-space tag write strobe |
| asid_wr_data | input | 8 | Address-space tag write value |
| entry_taken | output | 1 | One-cycle pulse after an entry |
| entry_cause | output | 2 | Code of the served cause |
| entry_resumable | output | 1 | Interrupted code may be resumed |
| pc_q | output | 32 | Program counter loaded on entry |
| status_q | output | 16 | Status word |
| saved_status_q | output | 16 | Status word saved on entry |
| ret_addr_q | output | 32 | Return address saved on entry |
| fault_va_q | output | 32 | Recorded failing virtual address |
| tlb_hi_q | output | 32 | Page number, buffer flag and address-space tag |
| vec_base_q | output | 32 | Vector base |

## Verification
Each cause is raised alone with distinct context values, so a swapped return-address source or vector offset shows up as a wrong value rather than a coincidental match. All request combinations are raised together to separate the three priority levels, and back-to-back entries with a software status write between them show whether the saved status is the live word or a constant. Software writes issued in the same cycle as a fault, and a prior non-zero address-space tag, tell dropped writes and preserved fields apart from overwritten ones; a long run of random requests and writes compares every output with a behavioural model on each clock.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_TLB  = 2'd1,
        CAUSE_DBUS = 2'd2,
        CAUSE_IBUS = 2'd3
    } cause_e;

    // status word field positions
    localparam int SR_FLAG_A   = 0;
    localparam int SR_FLAG_B   = 1;
    localparam int SR_MODE_LO  = 2;
    localparam int SR_MODE_HI  = 4;
    localparam int SR_EMASK    = 5;
    localparam int SR_GMASK    = 6;
    localparam int SR_LOW_BITS = 7;

    localparam logic [2:0] ENTRY_MODE = 3'b110;

    function automatic logic [7:0] vector_offset(cause_e c);
        case (c)
            CAUSE_TLB:  return 8'h04;
            CAUSE_DBUS: return 8'h08;
            CAUSE_IBUS: return 8'h0C;
            default:    return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] grant,
    output logic               any_req
);
    // index 0 wins over every higher index
    logic [NUM_SRC:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        assign grant[i]     = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    assign any_req = blocked[NUM_SRC];
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  cause_e              cause,
    input  logic [ADDR_W-1:0]   vec_base,
    input  logic [ADDR_W-1:0]   cur_pc,
    input  logic [ADDR_W-1:0]   unissued_pc,
    output logic [ADDR_W-1:0]   target_pc,
    output logic [ADDR_W-1:0]   ret_addr,
    output logic                resumable
);
    always_comb begin
        target_pc = vec_base + ADDR_W'(vector_offset(cause));
        ret_addr  = (cause == CAUSE_DBUS) ? unissued_pc : cur_pc;
        resumable = (cause == CAUSE_IBUS);
    end
endmodule

// File: rtl/exc_status_fmt.sv
module exc_status_fmt
    import exc_entry_pkg::*;
#(
    parameter int SR_W = 16
) (
    input  logic [SR_W-1:0] cur_sr,
    output logic [SR_W-1:0] entry_sr
);
    always_comb begin
        entry_sr                         = cur_sr;
        entry_sr[SR_FLAG_A]              = 1'b0;
        entry_sr[SR_FLAG_B]              = 1'b0;
        entry_sr[SR_MODE_HI:SR_MODE_LO]  = ENTRY_MODE;
        entry_sr[SR_EMASK]               = 1'b1;
        entry_sr[SR_GMASK]               = 1'b1;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SR_W       = 16,
    parameter int ASID_W     = 8,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_tlb_conflict,
    input  logic                     req_data_berr,
    input  logic                     req_fetch_berr,
    input  logic [ADDR_W-1:0]        ctx_pc,
    input  logic [ADDR_W-1:0]        ctx_unissued_pc,
    input  logic [ADDR_W-1:0]        ctx_fault_va,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] ctx_page,
    input  logic                     ctx_itlb,
    input  logic                     vb_wr_en,
    input  logic [ADDR_W-1:0]        vb_wr_data,
    input  logic                     sr_wr_en,
    input  logic [SR_W-1:0]          sr_wr_data,
    input  logic                     asid_wr_en,
    input  logic [ASID_W-1:0]        asid_wr_data,
    output logic                     entry_taken,
    output logic [1:0]               entry_cause,
    output logic                     entry_resumable,
    output logic [ADDR_W-1:0]        pc_q,
    output logic [SR_W-1:0]          status_q,
    output logic [SR_W-1:0]          saved_status_q,
    output logic [ADDR_W-1:0]        ret_addr_q,
    output logic [ADDR_W-1:0]        fault_va_q,
    output logic [ADDR_W-1:0]        tlb_hi_q,
    output logic [ADDR_W-1:0]        vec_base_q
);
    localparam int NUM_SRC = 3;
    localparam int VPN_W   = ADDR_W - PAGE_SHIFT;
    localparam int PAD_W   = PAGE_SHIFT - ASID_W - 1;

    localparam logic [SR_W-1:0] SR_RESET =
        SR_W'({1'b1, 1'b1, ENTRY_MODE, 2'b00});

    typedef struct packed {
        logic              taken;
        cause_e            cause;
        logic              resumable;
        logic [ADDR_W-1:0] pc;
        logic [SR_W-1:0]   sr;
        logic [SR_W-1:0]   saved_sr;
        logic [ADDR_W-1:0] ret;
        logic [ADDR_W-1:0] fault_va;
        logic [VPN_W-1:0]  vpn;
        logic              itlb;
        logic [ASID_W-1:0] asid;
        logic [ADDR_W-1:0] vb;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] req_vec;
    logic [NUM_SRC-1:0] grant;
    logic               any_req;
    cause_e             sel_cause;
    logic [ADDR_W-1:0]  target_pc;
    logic [ADDR_W-1:0]  ret_addr;
    logic               resumable;
    logic [SR_W-1:0]    entry_sr;

    // priority order follows the bit index: conflict, data error, fetch error
    assign req_vec = {req_fetch_berr, req_data_berr, req_tlb_conflict};

    exc_prio_arb #(
        .NUM_SRC (NUM_SRC)
    ) u_arb (
        .req     (req_vec),
        .grant   (grant),
        .any_req (any_req)
    );

    always_comb begin
        sel_cause = CAUSE_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) sel_cause = cause_e'(i + 1);
        end
    end

    exc_target_calc #(
        .ADDR_W (ADDR_W)
    ) u_target (
        .cause       (sel_cause),
        .vec_base    (st_q.vb),
        .cur_pc      (ctx_pc),
        .unissued_pc (ctx_unissued_pc),
        .target_pc   (target_pc),
        .ret_addr    (ret_addr),
        .resumable   (resumable)
    );

    exc_status_fmt #(
        .SR_W (SR_W)
    ) u_status (
        .cur_sr   (st_q.sr),
        .entry_sr (entry_sr)
    );

    always_comb begin
        st_d           = st_q;
        st_d.taken     = 1'b0;
        st_d.cause     = CAUSE_NONE;
        st_d.resumable = 1'b0;
        if (any_req) begin
            st_d.taken     = 1'b1;
            st_d.cause     = sel_cause;
            st_d.resumable = resumable;
            st_d.saved_sr  = st_q.sr;
            st_d.sr        = entry_sr;
            st_d.pc        = target_pc;
            st_d.ret       = ret_addr;
            if (sel_cause == CAUSE_TLB) begin
                st_d.fault_va = ctx_fault_va;
                st_d.vpn      = ctx_page;
                st_d.itlb     = ctx_itlb;
            end
        end else begin
            if (vb_wr_en)   st_d.vb   = vb_wr_data;
            if (sr_wr_en)   st_d.sr   = sr_wr_data;
            if (asid_wr_en) st_d.asid = asid_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.sr <= SR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign entry_taken     = st_q.taken;
    assign entry_cause     = st_q.cause;
    assign entry_resumable = st_q.resumable;
    assign pc_q            = st_q.pc;
    assign status_q        = st_q.sr;
    assign saved_status_q  = st_q.saved_sr;
    assign ret_addr_q      = st_q.ret;
    assign fault_va_q      = st_q.fault_va;
    assign tlb_hi_q        = {st_q.vpn, {PAD_W{1'b0}}, st_q.itlb, st_q.asid};
    assign vec_base_q      = st_q.vb;
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16,
    parameter int ASID_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_tlb_conflict,
    input logic              req_data_berr,
    input logic              req_fetch_berr,
    input logic              entry_taken,
    input logic [1:0]        entry_cause,
    input logic              entry_resumable,
    input logic [ADDR_W-1:0] pc_q,
    input logic [SR_W-1:0]   status_q,
    input logic [SR_W-1:0]   saved_status_q,
    input logic [ADDR_W-1:0] fault_va_q,
    input logic [ADDR_W-1:0] tlb_hi_q,
    input logic [ADDR_W-1:0] vec_base_q
);
    logic any_req;
    assign any_req = req_tlb_conflict | req_data_berr | req_fetch_berr;

    AST_REQ_GIVES_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> entry_taken); // R10
    AST_NO_REQ_NO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> !entry_taken && entry_cause == 2'd0); // R10
    AST_CONFLICT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_tlb_conflict |=> entry_cause == 2'd1); // R9
    AST_DATA_OVER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_tlb_conflict && req_data_berr) |=> entry_cause == 2'd2); // R9
    AST_SAVED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> saved_status_q == $past(status_q)); // R2
    AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        entry_taken |-> status_q[6:0] == 7'b1111000); // R3
    AST_VECTOR_PC: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> pc_q == $past(vec_base_q) + ADDR_W'({entry_cause, 2'b00})); // R4
    AST_ASID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_tlb_conflict |=> tlb_hi_q[ASID_W-1:0] == $past(tlb_hi_q[ASID_W-1:0])); // R7
    AST_BERR_MMU_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_tlb_conflict && any_req) |=> $stable(fault_va_q) && $stable(tlb_hi_q)); // R11
    AST_RESUMABLE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_resumable == (entry_taken && entry_cause == 2'd3)); // R8
endmodule

bind exc_entry_ctrl exc_entry_checker #(
    .ADDR_W (ADDR_W),
    .SR_W   (SR_W),
    .ASID_W (ASID_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_tlb_conflict (req_tlb_conflict),
    .req_data_berr    (req_data_berr),
    .req_fetch_berr   (req_fetch_berr),
    .entry_taken      (entry_taken),
    .entry_cause      (entry_cause),
    .entry_resumable  (entry_resumable),
    .pc_q             (pc_q),
    .status_q         (status_q),
    .saved_status_q   (saved_status_q),
    .fault_va_q       (fault_va_q),
    .tlb_hi_q         (tlb_hi_q),
    .vec_base_q       (vec_base_q)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        r_tlb = 0, r_dbus = 0, r_ibus = 0;
    logic [31:0] c_pc = 0, c_unis = 0, c_va = 0;
    logic [19:0] c_page = 0;
    logic        c_itlb = 0;
    logic        vb_we = 0, sr_we = 0, as_we = 0;
    logic [31:0] vb_wd = 0;
    logic [15:0] sr_wd = 0;
    logic [7:0]  as_wd = 0;

    logic        o_taken, o_res;
    logic [1:0]  o_cause;
    logic [31:0] o_pc, o_ret, o_va, o_hi, o_vb;
    logic [15:0] o_sr, o_ssr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_tlb_conflict(r_tlb), .req_data_berr(r_dbus), .req_fetch_berr(r_ibus),
        .ctx_pc(c_pc), .ctx_unissued_pc(c_unis), .ctx_fault_va(c_va),
        .ctx_page(c_page), .ctx_itlb(c_itlb),
        .vb_wr_en(vb_we), .vb_wr_data(vb_wd),
        .sr_wr_en(sr_we), .sr_wr_data(sr_wd),
        .asid_wr_en(as_we), .asid_wr_data(as_wd),
        .entry_taken(o_taken), .entry_cause(o_cause), .entry_resumable(o_res),
        .pc_q(o_pc), .status_q(o_sr), .saved_status_q(o_ssr),
        .ret_addr_q(o_ret), .fault_va_q(o_va), .tlb_hi_q(o_hi), .vec_base_q(o_vb)
    );

    // behavioural reference state
    int          m_taken, m_cause, m_res, m_multi;
    logic [31:0] m_pc, m_ret, m_va, m_vb;
    logic [19:0] m_page;
    logic        m_itlb;
    logic [7:0]  m_asid;
    logic [15:0] m_sr, m_ssr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_taken = 0; m_cause = 0; m_res = 0; m_multi = 0;
            m_pc = 0; m_ret = 0; m_va = 0; m_vb = 0; m_page = 0;
            m_itlb = 0; m_asid = 0; m_sr = 16'h0078; m_ssr = 0;
        end else begin
            m_taken = 0; m_cause = 0; m_res = 0;
            m_multi = (int'(r_tlb) + int'(r_dbus) + int'(r_ibus)) > 1;
            if (r_tlb || r_dbus || r_ibus) begin
                m_cause = r_tlb ? 1 : (r_dbus ? 2 : 3);
                m_taken = 1;
                m_ssr   = m_sr;
                m_sr    = (m_sr & 16'hFF80) | 16'h0078;
                m_pc    = m_vb + 32'(4 * m_cause);
                m_ret   = (m_cause == 2) ? c_unis : c_pc;
                m_res   = (m_cause == 3);
                if (m_cause == 1) begin
                    m_va = c_va; m_page = c_page; m_itlb = c_itlb;
                end
            end else begin
                if (vb_we) m_vb = vb_wd;
                if (sr_we) m_sr = sr_wd;
                if (as_we) m_asid = as_wd;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    task automatic compare_all();
        logic [31:0] hi_exp;
        hi_exp = {m_page, 3'b000, m_itlb, m_asid};
        chk(m_multi ? "R9 taken" : "R10 taken", 32'(o_taken), 32'(m_taken));
        chk(m_multi ? "R9 cause" : "R10 cause", 32'(o_cause), 32'(m_cause));
        chk("R8 resumable", 32'(o_res), 32'(m_res));
        chk("R4 pc", o_pc, m_pc);
        chk(m_taken != 0 ? "R3 status" : "R12 status", 32'(o_sr), 32'(m_sr));
        chk("R2 saved status", 32'(o_ssr), 32'(m_ssr));
        chk("R5 return address", o_ret, m_ret);
        chk(m_cause == 1 ? "R6 fault va" : "R11 fault va", o_va, m_va);
        chk(m_cause == 1 ? "R6 tlb hi" : "R11 tlb hi", {o_hi[31:8], 8'h00}, {hi_exp[31:8], 8'h00});
        chk(m_cause == 1 ? "R7 asid" : "R12 asid", 32'(o_hi[7:0]), 32'(m_asid));
        chk("R12 vector base", o_vb, m_vb);
    endtask

    task automatic idle_inputs();
        r_tlb = 0; r_dbus = 0; r_ibus = 0;
        vb_we = 0; sr_we = 0; as_we = 0;
    endtask

    task automatic set_ctx(logic [31:0] pc, logic [31:0] un, logic [31:0] va,
                           logic [19:0] pg, logic it);
        c_pc = pc; c_unis = un; c_va = va; c_page = pg; c_itlb = it;
    endtask

    // one step: check the state present now, then drive the next inputs
    task automatic step(logic t, logic d, logic i);
        @(negedge clk);
        compare_all();
        idle_inputs();
        r_tlb = t; r_dbus = d; r_ibus = i;
    endtask

    initial begin : watchdog
        while (cycles < 20000) @(posedge clk) cycles++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1 status", 32'(o_sr), 32'h0078);
        chk("R1 taken", 32'(o_taken), 0);
        chk("R1 cause", 32'(o_cause), 0);
        chk("R1 pc", o_pc, 0);
        chk("R1 vector base", o_vb, 0);
        chk("R1 tlb hi", o_hi, 0);
        chk("R1 fault va", o_va, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after release", 32'(o_sr), 32'h0078);
        chk("R1 saved after release", 32'(o_ssr), 0);

        // software writes
        vb_we = 1; vb_wd = 32'h0000_4000;
        sr_we = 1; sr_wd = 16'hA583;
        as_we = 1; as_wd = 8'h5A;
        set_ctx(32'h1111_0010, 32'h1111_0024, 32'hDEAD_B000, 20'hDEADB, 1'b1);
        step(0, 0, 0);
        // translation conflict alone, instruction buffer
        step(1, 0, 0);
        step(0, 0, 0);
        // live status change between entries
        sr_we = 1; sr_wd = 16'h3C07;
        step(0, 0, 0);
        set_ctx(32'h2222_0040, 32'h2222_0048, 32'h0BAD_0000, 20'h0BAD0, 1'b0);
        step(0, 1, 0);
        step(0, 0, 0);
        set_ctx(32'h3333_0100, 32'h3333_0108, 32'h7777_7000, 20'h77777, 1'b0);
        step(0, 0, 1);
        step(0, 0, 0);
        // all three together, then the two bus errors together
        set_ctx(32'h4444_0200, 32'h4444_0210, 32'hCAFE_1000, 20'hCAFE1, 1'b0);
        step(1, 1, 1);
        step(0, 1, 1);
        step(0, 0, 0);
        // writes coinciding with a fault are dropped
        step(0, 0, 1);
        vb_we = 1; vb_wd = 32'h0000_8000;
        sr_we = 1; sr_wd = 16'hFFFF;
        as_we = 1; as_wd = 8'h33;
        step(0, 0, 0);
        step(1, 0, 0);
        vb_we = 1; vb_wd = 32'h0001_0000;
        as_we = 1; as_wd = 8'hC4;
        step(0, 0, 0);

        // random traffic
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            compare_all();
            idle_inputs();
            r_tlb  = ($urandom % 6) == 0;
            r_dbus = ($urandom % 6) == 0;
            r_ibus = ($urandom % 6) == 0;
            vb_we  = ($urandom % 4) == 0; vb_wd = $urandom & 32'hFFFF_FFFC;
            sr_we  = ($urandom % 4) == 0; sr_wd = 16'($urandom);
            as_we  = ($urandom % 4) == 0; as_wd = 8'($urandom);
            set_ctx($urandom, $urandom, $urandom, 20'($urandom), 1'($urandom));
        end
        step(0, 0, 0);
        step(0, 0, 0);
        @(negedge clk);
        compare_all();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule